// File: doc/BRIEF.md
# Duty-Corrected Programmable Clock Divider

This block is the post-scale stage of a clock generator. It divides a fast source clock by a programmable ratio. The ratio is set as two separate counts: the number of source cycles the output stays high and the number it stays low. When the ratio is odd, an odd-division flag gives the nearest possible approach to a 50% duty cycle. It does this by ending the high phase half a source cycle early. A falling-edge register on the source clock supplies that half-cycle step. A bypass setting passes the source clock straight to the output.

Settings arrive as one configuration word together with a single-cycle load strobe. The word is held as pending until the current output period ends. It then becomes active at the rising edge that starts the next period. A change of setting therefore never cuts a high or low phase short. A count of zero in either field acts as a count of one, so the divider cannot stall.

Top module: `dutyfix_divider`

## Requirements
- R1: While reset is asserted the output is low. After reset the divider runs with the default counts RST_LO and RST_HI (both 1), with odd and bypass off.
- R2: Outside bypass, one output period lasts max(1,low)+max(1,high) source cycles.
- R3: The configuration word holds the low count in bits [7:0], the high count in bits [15:8], bypass in bit 16 and the odd flag in bit 17.
- R4: With the odd flag clear, the output is high for exactly max(1,high) source cycles of each period.
- R5: With the odd flag set, the output is high for max(1,high) minus one half source cycle. It falls on the falling source edge of the last high cycle.
- R6: With bypass set, the output follows the source clock: one source cycle per period, high for half of it.
- R7: A loaded word takes effect only at the rising edge that ends the current output period. Every period is entirely of the old or the new setting. The new setting is in force from the second full period after the load.
- R8: A zero in either count field behaves exactly like a one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 18 | Configuration: low count, high count, bypass, odd flag |
| cfg_load | input | 1 | One-cycle strobe that captures cfg_word as pending |
| clk_out | output | 1 | Divided (or bypassed) output clock |

## Verification
The bench builds the block with its defaults: 8-bit count fields and reset counts of one each. It sweeps both count fields over 0 to 5 with the odd flag clear and set, and adds bypass entries. This covers the zero-as-one rule, the ratio-of-two corner with a half-cycle high pulse, and every switch between settings. The output is sampled twice per source cycle, so the high time and the period are measured in half-cycle units. Each period seen across a reconfiguration is matched against the old and new expected pair, which exposes any runt pulse.

// File: rtl/dutyfix_pkg.sv
package dutyfix_pkg;
    localparam int CNT_W = 8;
    localparam int WORD_W = 2 * CNT_W + 2;

    // Bit order matters: low [CNT_W-1:0], high next, then bypass, then odd
    typedef struct packed {
        logic             odd;
        logic             byp;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } div_cfg_t;

    function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction
endpackage

// File: rtl/dutyfix_cfg_hold.sv
module dutyfix_cfg_hold
    import dutyfix_pkg::*;
#(
    parameter int RST_LO = 1,
    parameter int RST_HI = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t cfg_in,
    input  logic     cfg_load,
    input  logic     boundary,
    output div_cfg_t act_o
);
    typedef struct packed {
        div_cfg_t pend;
        logic     pend_v;
        div_cfg_t act;
    } hold_t;

    localparam div_cfg_t RST_CFG = '{odd: 1'b0, byp: 1'b0,
                                     hi: CNT_W'(RST_HI), lo: CNT_W'(RST_LO)};

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary && st_q.pend_v) begin
            st_d.act = st_q.pend;
        end
        if (cfg_load) begin
            st_d.pend   = cfg_in;
            st_d.pend_v = 1'b1;
        end else if (boundary) begin
            st_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend   <= RST_CFG;
            st_q.pend_v <= 1'b0;
            st_q.act    <= RST_CFG;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;
endmodule

// File: rtl/dutyfix_phase_cnt.sv
module dutyfix_phase_cnt
    import dutyfix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  div_cfg_t         act,
    output logic             phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             boundary_o,
    output logic             last_hi_o
);
    typedef struct packed {
        logic             phase;
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] lo_end, hi_end;
    logic end_lo, end_hi;

    always_comb begin
        lo_end = eff_count(act.lo) - 1'b1;
        hi_end = eff_count(act.hi) - 1'b1;
        end_lo = !st_q.phase && (st_q.cnt == lo_end);
        end_hi = st_q.phase && (st_q.cnt == hi_end);
        boundary_o = act.byp || end_lo;
        last_hi_o  = end_hi && act.odd && !act.byp;

        st_d = st_q;
        if (boundary_o) begin
            st_d.phase = 1'b1;
            st_d.cnt   = '0;
        end else if (end_hi) begin
            st_d.phase = 1'b0;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= 1'b0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/dutyfix_edge_out.sv
module dutyfix_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic phase,
    input  logic last_hi,
    input  logic byp,
    output logic fall_o,
    output logic clk_out
);
    logic fall_d, fall_q;

    // Sampled on the falling edge: drops the output mid-cycle in the last high cycle
    always_comb fall_d = !last_hi;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b1;
        else        fall_q <= fall_d;
    end

    assign fall_o  = fall_q;
    assign clk_out = byp ? clk : (phase && fall_q);
endmodule

// File: rtl/dutyfix_divider.sv
module dutyfix_divider
    import dutyfix_pkg::*;
#(
    parameter int RST_LO = 1,
    parameter int RST_HI = 1
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_load,
    output logic              clk_out
);
    div_cfg_t         act;
    logic             phase_w;
    logic [CNT_W-1:0] cnt_w;
    logic             boundary_w;
    logic             last_hi_w;
    logic             fall_w;

    dutyfix_cfg_hold #(.RST_LO(RST_LO), .RST_HI(RST_HI)) u_hold (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .cfg_in   (div_cfg_t'(cfg_word)),
        .cfg_load (cfg_load),
        .boundary (boundary_w),
        .act_o    (act)
    );

    dutyfix_phase_cnt u_cnt (
        .clk        (clk_src),
        .rst_n      (rst_n),
        .act        (act),
        .phase_o    (phase_w),
        .cnt_o      (cnt_w),
        .boundary_o (boundary_w),
        .last_hi_o  (last_hi_w)
    );

    dutyfix_edge_out u_edge (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .phase   (phase_w),
        .last_hi (last_hi_w),
        .byp     (act.byp),
        .fall_o  (fall_w),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/dutyfix_checker.sv
module dutyfix_checker
    import dutyfix_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input div_cfg_t         act,
    input logic             phase_w,
    input logic [CNT_W-1:0] cnt_w,
    input logic             boundary_w,
    input logic             fall_w,
    input logic             clk_out
);
    // R1
    always @(negedge clk) begin
        if (rst_n == 1'b0) begin
            out_low_in_reset_chk: assert (clk_out == 1'b0);
        end
    end

    // R7
    cfg_switch_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(boundary_w));

    // R2
    new_period_from_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act.byp && $rose(phase_w)) |-> $past(boundary_w));

    // R8
    high_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_w && !act.byp) |-> (cnt_w < eff_count(act.hi)));

    // R8
    low_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_w && !act.byp) |-> (cnt_w < eff_count(act.lo)));

    // R5
    half_cut_only_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_w |-> (phase_w && act.odd && !act.byp));

    // R6
    bypass_each_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act.byp |-> boundary_w);
endmodule

bind dutyfix_divider dutyfix_checker u_chk (
    .clk        (clk_src),
    .rst_n      (rst_n),
    .act        (act),
    .phase_w    (phase_w),
    .cnt_w      (cnt_w),
    .boundary_w (boundary_w),
    .fall_w     (fall_w),
    .clk_out    (clk_out)
);

// File: tb/sim_dutyfix_divider.sv
`timescale 1ns/1ps
module sim_dutyfix_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] cfg_word = '0;
    logic        cfg_load = 1'b0;
    logic        clk_out;

    int total = 0;
    int bad = 0;

    dutyfix_divider u0 (
        .clk_src  (clk),
        .rst_n    (rst_n),
        .cfg_word (cfg_word),
        .cfg_load (cfg_load),
        .clk_out  (clk_out)
    );

    always #5 clk = ~clk;

    // Half-cycle sampled period measurement (rising to rising)
    logic prev_s = 1'b0;
    int acc_tot = 0, acc_hi = 0;
    int p_tot = 0, p_hi = 0, p_seq = 0;

    task automatic take_sample(input logic s);
        if (!prev_s && s) begin
            p_tot = acc_tot;
            p_hi  = acc_hi;
            p_seq = p_seq + 1;
            acc_tot = 1;
            acc_hi  = 1;
        end else begin
            acc_tot = acc_tot + 1;
            acc_hi  = acc_hi + (s ? 1 : 0);
        end
        prev_s = s;
    endtask

    always @(posedge clk) begin #2; take_sample(clk_out); end
    always @(negedge clk) begin #2; take_sample(clk_out); end

    task automatic wait_period();
        int s0;
        s0 = p_seq;
        while (p_seq == s0) @(negedge clk);
    endtask

    function automatic void expect_of(input logic [17:0] w, output int et, output int eh);
        int lo, hi;
        if (w[16]) begin
            et = 2; eh = 1;
        end else begin
            lo = (w[7:0] == 0) ? 1 : int'(w[7:0]);
            hi = (w[15:8] == 0) ? 1 : int'(w[15:8]);
            et = 2 * (lo + hi);
            eh = 2 * hi - (w[17] ? 1 : 0);
        end
    endfunction

    task automatic check(input bit ok, input string req, input int at, input int ah,
                         input int et, input int eh);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: got period=%0d high=%0d expected period=%0d high=%0d (half cycles)",
                     req, at, ah, et, eh);
        end
    endtask

    logic [17:0] cur_word;

    task automatic run_cfg(input logic [17:0] w);
        int ot, oh, nt, nh;
        string tag;
        expect_of(cur_word, ot, oh);
        expect_of(w, nt, nh);
        if (w[16])                          tag = "R6 bypass";
        else if (w[7:0] == 0 || w[15:8] == 0) tag = "R8 zero count";
        else if (w[17])                     tag = "R5 odd flag, R2 ratio";
        else                                tag = "R4 even duty, R2 ratio";
        @(negedge clk);
        cfg_word = w;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_word = '0;
        for (int k = 0; k < 4; k++) begin
            wait_period();
            if (k < 2)
                check((p_tot == ot && p_hi == oh) || (p_tot == nt && p_hi == nh),
                      "R7 no runt across change", p_tot, p_hi, nt, nh);
            else
                check(p_tot == nt && p_hi == nh, tag, p_tot, p_hi, nt, nh);
        end
        cur_word = w;
    endtask

    initial begin
        #2000000;
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_word = 18'h00101;
        // R1 output low in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check(clk_out == 1'b0, "R1 reset low", int'(clk_out), 0, 0, 0);
        end
        rst_n = 1'b1;
        // R1 default counts after reset (first period skipped)
        wait_period();
        for (int i = 0; i < 2; i++) begin
            wait_period();
            check(p_tot == 4 && p_hi == 2, "R1 default ratio", p_tot, p_hi, 4, 2);
        end
        // R3 field layout: lo bits[7:0], hi bits[15:8], bypass bit16, odd bit17
        run_cfg({1'b0, 1'b0, 8'd1, 8'd3});
        run_cfg({1'b0, 1'b0, 8'd3, 8'd1});
        // sweep
        for (int od = 0; od < 2; od++)
            for (int hi = 0; hi < 6; hi++)
                for (int lo = 0; lo < 6; lo++)
                    run_cfg({od[0], 1'b0, 8'(hi), 8'(lo)});
        // R6 bypass in and out
        run_cfg({1'b1, 1'b1, 8'd2, 8'd2});
        run_cfg({1'b1, 1'b0, 8'd3, 8'd2});
        run_cfg({1'b0, 1'b1, 8'd4, 8'd4});
        run_cfg({1'b0, 1'b0, 8'd1, 8'd1});
        run_cfg({1'b1, 1'b0, 8'd1, 8'd1});
        run_cfg({1'b0, 1'b0, 8'd200, 8'd7});
        run_cfg({1'b1, 1'b1, 8'd0, 8'd0});
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule